// File: doc/BRIEF.md
# Dual-Line Page Program Receiver

This block is the device-side front end of a serial flash slave for one command: a page program whose data arrives two bits per serial clock. The pins are sampled by the system clock. While the select input is low, the block shifts in an 8-bit opcode and a 24-bit address on line 0. It then collects data bytes four serial clocks at a time into a 256-byte page buffer. At the start of every frame the buffer is refilled with ones.

When the select input returns high, the frame commits only if all of these hold:
- the opcode matches;
- at least one whole byte arrived;
- the frame ended on a byte boundary;
- the write-enable latch is set;
- the target page is outside the protected region.

A committed frame starts a self-timed program cycle of a fixed number of system clocks. The cycle can be suspended and resumed. When it ends, the buffer is ANDed into a small on-chip array model. Two status bytes can be read at any time, so a host can poll them for completion.

Top module: `dual_prog_rx`

## Requirements
- R1: Each frame opens, after the select falls, with 32 serial clocks carrying an opcode byte and then a 24-bit address, both MSB first on line 0. Line 1 is ignored during these clocks. Only opcode 0xA2 can commit.
- R2: After the header, each serial clock carries two bits: line 1 then line 0 give bits (7,6), (5,4), (3,2) and (1,0), in that order, so one byte takes four serial clocks.
- R3: The first data byte lands at the buffer offset given by address bits 7:0. Later bytes go to rising offsets that wrap within the 256-byte page, so from the 257th byte on a later byte overwrites an earlier one.
- R4: The frame commits only if the select rises after a complete data byte. A rise mid-byte, or a rise before any data byte, discards the frame with no effect.
- R5: A pulse on `wren` sets the write-enable latch (status bit 1) while no cycle runs. If the latch is clear when the select rises, the frame is ignored and busy never asserts.
- R6: Let the protected span be 0 pages when `bp`=0 and min(PAGES, 2^(bp-1)) pages otherwise. It covers the lowest pages when `tb`=1 and the highest pages when `tb`=0. A frame whose page (address bits 8 and up, modulo PAGES) lies in the span does not commit.
- R7: From the clock edge that samples the select rise of a committing frame, status bit 0 (busy) is set and flag bit 7 (ready) is cleared for exactly T_PROG non-suspended system clocks.
- R8: The write-enable latch clears on the edge where the program cycle starts.
- R9: At completion each byte of the target page becomes old AND buffer, so bits only go from 1 to 0. Offsets that received no data stay unchanged.
- R10: A `susp_req` pulse during a cycle sets flag bit 2 and freezes the cycle's progress. A `resume_req` pulse clears the bit, and the cycle continues from the point where it stopped.
- R11: After reset every array byte reads 0xFF, the status byte reads 0x00 and the flag byte reads 0x80.
- R12: While a cycle runs, `wren` pulses and whole frames whose select falls during the cycle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, sampled on its rising level change |
| dq0 | input | 1 | Data line 0 |
| dq1 | input | 1 | Data line 1 |
| wren | input | 1 | Pulse that sets the write-enable latch |
| susp_req | input | 1 | Pulse that suspends a running cycle |
| resume_req | input | 1 | Pulse that resumes a suspended cycle |
| bp | input | 4 | Protection span code |
| tb | input | 1 | Protection from the bottom (1) or the top (0) |
| rd_addr | input | log2(PAGES)+8 | Array model byte read address |
| rd_data | output | 8 | Array model byte at rd_addr |
| status | output | 8 | Bit 0 busy, bit 1 write-enable latch |
| flag | output | 8 | Bit 7 ready, bit 2 suspended |

## Verification
Frames are driven with garbage toggling on line 1 during the header and with data bytes that mix both lines, so a swapped line or a swapped bit pair shows up in the stored byte. A second program to the same offsets separates an AND merge from a plain overwrite. A run that starts near the end of a page, and another of 258 bytes, separate page wrap from carry into the next page. Frames cut mid-byte, frames with no data, a wrong opcode, a clear latch, protected pages under both `tb` settings, and frames during a running cycle must all leave the array and the status unchanged. A suspended stretch in the middle of a cycle must lengthen busy by exactly its own length.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
   localparam logic [7:0] OPC_DUAL_PROG = 8'hA2;
   localparam int         HDR_BITS      = 32;
   localparam int         PAGE_BYTES    = 256;
   localparam int         PAIRS_PER_B   = 4;
   localparam int         STAT_BUSY     = 0;
   localparam int         STAT_WEL      = 1;
   localparam int         FLAG_SUSP     = 2;
   localparam int         FLAG_READY    = 7;
endpackage

// File: rtl/dpr_shifter.sv
module dpr_shifter
   import dpr_pkg::*;
#(
   parameter bit SCLK_RISE = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cs_n,
   input  logic        sclk,
   input  logic        dq0,
   input  logic        dq1,
   input  logic        idle,
   output logic        frame_start,
   output logic        cs_rise,
   output logic        frame_ok,
   output logic [23:0] addr,
   output logic        wr_en,
   output logic [7:0]  wr_idx,
   output logic [7:0]  wr_data
);
   localparam int HCW = $clog2(HDR_BITS + 1);

   logic           cs_q, sclk_q, active, got_byte, sck_edge, shift_ev, hdr_done;
   logic [HCW-1:0] hdr_cnt;
   logic [HDR_BITS-1:0] hdr_sr;
   logic [1:0]     pair_cnt;
   logic [5:0]     byte_sr;
   logic [7:0]     byte_idx;

   generate
      if (SCLK_RISE) begin : g_rise
         assign sck_edge = sclk & ~sclk_q;
      end else begin : g_fall
         assign sck_edge = ~sclk & sclk_q;
      end
   endgenerate

   assign hdr_done    = (hdr_cnt == HCW'(HDR_BITS));
   assign shift_ev    = active & ~cs_n & sck_edge;
   assign frame_start = cs_q & ~cs_n & idle;
   assign cs_rise     = ~cs_q & cs_n;
   assign addr        = hdr_sr[23:0];
   assign frame_ok    = active & hdr_done & got_byte & (pair_cnt == 2'd0)
                        & (hdr_sr[HDR_BITS-1 -: 8] == OPC_DUAL_PROG);
   assign wr_en       = shift_ev & hdr_done & (pair_cnt == 2'(PAIRS_PER_B - 1));
   assign wr_idx      = byte_idx;
   assign wr_data     = {byte_sr, dq1, dq0};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cs_q     <= 1'b1;
         sclk_q   <= 1'b0;
         active   <= 1'b0;
         got_byte <= 1'b0;
         hdr_cnt  <= '0;
         hdr_sr   <= '0;
         pair_cnt <= '0;
         byte_sr  <= '0;
         byte_idx <= '0;
      end else begin
         cs_q   <= cs_n;
         sclk_q <= sclk;
         if (cs_q && !cs_n) begin
            active   <= idle;
            hdr_cnt  <= '0;
            pair_cnt <= '0;
            got_byte <= 1'b0;
         end else if (cs_rise) begin
            active <= 1'b0;
         end else if (shift_ev) begin
            if (!hdr_done) begin
               hdr_sr  <= {hdr_sr[HDR_BITS-2:0], dq0};
               hdr_cnt <= hdr_cnt + 1'b1;
               if (hdr_cnt == HCW'(HDR_BITS - 1))
                  byte_idx <= {hdr_sr[6:0], dq0};
            end else begin
               byte_sr  <= {byte_sr[3:0], dq1, dq0};
               pair_cnt <= pair_cnt + 1'b1;
               if (pair_cnt == 2'(PAIRS_PER_B - 1)) begin
                  byte_idx <= byte_idx + 1'b1;
                  got_byte <= 1'b1;
               end
            end
         end
      end
   end

   a_r1_hdr_bound: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_cnt <= HCW'(HDR_BITS));
   a_r2_byte_after_hdr: assert property (@(posedge clk) disable iff (!rst_n)
      got_byte |-> hdr_done);
endmodule

// File: rtl/dpr_protect.sv
module dpr_protect #(
   parameter int PW = 2
) (
   input  logic [3:0]    bp,
   input  logic          tb,
   input  logic [PW-1:0] page,
   output logic          prot
);
   localparam int PAGES = 1 << PW;

   logic [PW:0] span;

   always_comb begin
      if (bp == 4'd0)
         span = '0;
      else if (32'(bp) - 1 >= PW)
         span = (PW+1)'(PAGES);
      else
         span = (PW+1)'(1) << (bp - 4'd1);
   end

   generate
      if (PW == 0) begin : g_one
         assign prot = (span != '0);
      end else begin : g_many
         assign prot = tb ? ({1'b0, page} < span)
                          : ({1'b0, page} >= ((PW+1)'(PAGES) - span));
      end
   endgenerate
endmodule

// File: rtl/dpr_engine.sv
module dpr_engine #(
   parameter int T_PROG = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic wren,
   input  logic susp_req,
   input  logic resume_req,
   output logic busy,
   output logic wel,
   output logic susp,
   output logic done
);
   localparam int CW = (T_PROG > 2) ? $clog2(T_PROG) : 1;

   logic [CW-1:0] cnt;

   assign done = busy & ~susp & (cnt == CW'(T_PROG - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         wel  <= 1'b0;
         susp <= 1'b0;
         cnt  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         wel  <= 1'b0;
         susp <= 1'b0;
         cnt  <= '0;
      end else begin
         if (done)
            busy <= 1'b0;
         else if (busy && !susp)
            cnt <= cnt + 1'b1;
         if (busy && !done) begin
            if (susp_req)
               susp <= 1'b1;
            else if (resume_req)
               susp <= 1'b0;
         end
         if (wren && !busy)
            wel <= 1'b1;
      end
   end

   a_r8_wel_drop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !wel);
   a_r10_susp_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      susp |-> busy);
   a_r10_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && susp && $past(busy) && $past(susp)) |-> $stable(cnt));
   a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt <= CW'(T_PROG - 1)));
   a_r12_wel_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && busy) |-> !$rose(wel));
endmodule

// File: rtl/dual_prog_rx.sv
module dual_prog_rx
   import dpr_pkg::*;
#(
   parameter int PAGES     = 4,
   parameter int T_PROG    = 64,
   parameter bit SCLK_RISE = 1'b1,
   localparam int PW = $clog2(PAGES),
   localparam int AW = PW + 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_n,
   input  logic          sclk,
   input  logic          dq0,
   input  logic          dq1,
   input  logic          wren,
   input  logic          susp_req,
   input  logic          resume_req,
   input  logic [3:0]    bp,
   input  logic          tb,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_data,
   output logic [7:0]    status,
   output logic [7:0]    flag
);
   localparam int ARR_BYTES = PAGES * PAGE_BYTES;

   generate
      if (PAGES < 2 || (PAGES & (PAGES - 1)) != 0) begin : g_bad_pages
         $error("PAGES must be a power of two of at least 2");
      end
      if (T_PROG < 2) begin : g_bad_tprog
         $error("T_PROG must be at least 2");
      end
   endgenerate

   logic          frame_start, cs_rise, frame_ok, wr_en, prot;
   logic          busy, wel, susp, done, start;
   logic [23:0]   addr;
   logic [7:0]    wr_idx, wr_data;
   logic [PW-1:0] tgt_page, prog_page;
   logic [7:0]    pbuf [PAGE_BYTES];
   logic [7:0]    arr  [ARR_BYTES];

   dpr_shifter #(.SCLK_RISE(SCLK_RISE)) u_shift (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .dq0(dq0), .dq1(dq1),
      .idle(~busy), .frame_start(frame_start), .cs_rise(cs_rise),
      .frame_ok(frame_ok), .addr(addr), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data)
   );

   assign tgt_page = addr[8 +: PW];

   dpr_protect #(.PW(PW)) u_prot (
      .bp(bp), .tb(tb), .page(tgt_page), .prot(prot)
   );

   assign start = cs_rise & frame_ok & wel & ~busy & ~prot;

   dpr_engine #(.T_PROG(T_PROG)) u_eng (
      .clk(clk), .rst_n(rst_n), .start(start), .wren(wren),
      .susp_req(susp_req), .resume_req(resume_req),
      .busy(busy), .wel(wel), .susp(susp), .done(done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'hFF;
      end else if (frame_start) begin
         for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'hFF;
      end else if (wr_en) begin
         pbuf[wr_idx] <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         prog_page <= '0;
      else if (start)
         prog_page <= tgt_page;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ARR_BYTES; i++) arr[i] <= 8'hFF;
      end else if (done) begin
         for (int i = 0; i < PAGE_BYTES; i++)
            arr[{prog_page, 8'(i)}] <= arr[{prog_page, 8'(i)}] & pbuf[i];
      end
   end

   assign rd_data = arr[rd_addr];

   always_comb begin
      status = '0;
      status[STAT_BUSY] = busy;
      status[STAT_WEL]  = wel;
      flag = '0;
      flag[FLAG_READY] = ~busy;
      flag[FLAG_SUSP]  = susp;
   end

   a_r5_busy_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wel));
   a_r9_buf_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && busy) |-> !$past(wr_en));
   a_r4_start_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cs_n));
endmodule

// File: tb/dual_prog_rx_test.sv
module dual_prog_rx_test;
   localparam int PAGES  = 4;
   localparam int T_PROG = 200;
   localparam int AW     = 10;
   localparam int NBYTES = PAGES * 256;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs_n = 1'b1, sclk = 1'b0, dq0 = 1'b0, dq1 = 1'b0;
   logic          wren = 1'b0, susp_req = 1'b0, resume_req = 1'b0;
   logic [3:0]    bp = 4'd0;
   logic          tb = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [7:0]    rd_data, status, flag;

   int vectors = 0, miscompares = 0, cycles = 0;
   bit finished = 0;

   // reference model state
   bit        m_busy = 0, m_wel = 0, m_susp = 0, m_pend = 0;
   int        m_cnt = 0, m_page = 0;
   logic [7:0] m_arr [NBYTES];
   logic [7:0] m_img [256];
   logic [7:0] tx [300];
   bit        hold = 0;
   logic [AW-1:0] hold_addr = '0;

   dual_prog_rx #(.PAGES(PAGES), .T_PROG(T_PROG)) uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .dq0(dq0), .dq1(dq1),
      .wren(wren), .susp_req(susp_req), .resume_req(resume_req), .bp(bp), .tb(tb),
      .rd_addr(rd_addr), .rd_data(rd_data), .status(status), .flag(flag)
   );

   always #2 clk = ~clk;

   initial for (int i = 0; i < NBYTES; i++) m_arr[i] = 8'hFF;

   // cycle model
   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_wel = 0; m_susp = 0; m_pend = 0; m_cnt = 0;
         for (int i = 0; i < NBYTES; i++) m_arr[i] = 8'hFF;
      end else if (m_pend) begin
         m_busy = 1; m_cnt = 0; m_wel = 0; m_susp = 0; m_pend = 0;
      end else if (m_busy) begin
         if (!m_susp) begin
            if (m_cnt == T_PROG - 1) begin
               for (int i = 0; i < 256; i++)
                  m_arr[m_page*256 + i] = m_arr[m_page*256 + i] & m_img[i];
               m_busy = 0;
            end else m_cnt++;
         end
         if (m_busy) begin
            if (susp_req) m_susp = 1;
            else if (resume_req) m_susp = 0;
         end
      end else if (wren) m_wel = 1;
   end

   // per-cycle compare
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         vectors += 3;
         if (status !== {6'b0, m_wel, m_busy}) begin
            miscompares++;
            $display("FAIL R5 R7 R8 status act=%h exp=%h t=%0t", status, {6'b0, m_wel, m_busy}, $time);
         end
         if (flag !== {~m_busy, 4'b0, m_susp, 2'b0}) begin
            miscompares++;
            $display("FAIL R7 R10 flag act=%h exp=%h t=%0t", flag, {~m_busy, 4'b0, m_susp, 2'b0}, $time);
         end
         if (rd_data !== m_arr[rd_addr]) begin
            miscompares++;
            $display("FAIL R9 array[%h] act=%h exp=%h", rd_addr, rd_data, m_arr[rd_addr]);
         end
      end
      rd_addr = hold ? hold_addr : rd_addr + 1'b1;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !finished) begin
         miscompares++;
         $display("FAIL watchdog expired");
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   function automatic bit prot_hit(int page, logic [3:0] b, logic t);
      int span;
      span = (b == 0) ? 0 : ((b - 1 >= 2) ? PAGES : (1 << (b - 1)));
      return t ? (page < span) : (page >= PAGES - span);
   endfunction

   task automatic pulse(ref logic s);
      @(negedge clk) s = 1'b1;
      @(negedge clk) s = 1'b0;
   endtask

   task automatic send_pair(input logic b1, input logic b0);
      @(negedge clk); sclk = 1'b0; dq1 = b1; dq0 = b0;
      @(negedge clk); sclk = 1'b1;
   endtask

   task automatic send_frame(input logic [7:0] opc, input logic [23:0] a,
                             input int nb, input int extra);
      bit idle0, ok;
      logic [31:0] hdr;
      int pg;
      hdr = {opc, a};
      @(negedge clk); cs_n = 1'b0; idle0 = !m_busy;
      for (int i = 31; i >= 0; i--) send_pair(i[0], hdr[i]);
      for (int k = 0; k < nb; k++)
         for (int p = 3; p >= 0; p--) send_pair(tx[k][2*p+1], tx[k][2*p]);
      for (int e = 0; e < extra; e++) send_pair(e[0], 1'b1);
      @(negedge clk); sclk = 1'b0;
      @(negedge clk); cs_n = 1'b1;
      pg = int'(a[9:8]);
      ok = idle0 && opc == 8'hA2 && nb > 0 && extra == 0 && m_wel && !prot_hit(pg, bp, tb);
      if (ok) begin
         for (int i = 0; i < 256; i++) m_img[i] = 8'hFF;
         for (int k = 0; k < nb; k++) m_img[(int'(a[7:0]) + k) % 256] = tx[k];
         m_page = pg;
         m_pend = 1;
      end
      @(negedge clk);
   endtask

   task automatic wait_idle();
      while (m_busy || m_pend) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic check_mem(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
      hold_addr = a; hold = 1;
      repeat (2) @(negedge clk);
      #1;
      vectors++;
      if (rd_data !== exp) begin
         miscompares++;
         $display("FAIL %s mem[%h] act=%h exp=%h", tag, a, rd_data, exp);
      end
      hold = 0;
   endtask

   task automatic check_byte(input logic [7:0] act, input logic [7:0] exp, input string tag);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R11 reset state
      check_byte(status, 8'h00, "R11 status");
      check_byte(flag, 8'h80, "R11 flag");
      check_mem(10'h000, 8'hFF, "R11");

      // R5: no latch, no program
      tx[0] = 8'h12;
      send_frame(8'hA2, 24'h000010, 1, 0);
      repeat (5) @(negedge clk); #1;
      check_byte(status, 8'h00, "R5 no busy");
      check_mem(10'h010, 8'hFF, "R5");

      // R1 R2: header with junk on line 1, two bytes
      pulse(wren);
      @(negedge clk); #1;
      check_byte(status, 8'h02, "R5 latch set");
      tx[0] = 8'hA5; tx[1] = 8'h3C;
      send_frame(8'hA2, 24'h000105, 2, 0);
      #1; check_byte(status, 8'h01, "R8 latch clear at start");
      wait_idle();
      check_mem(10'h105, 8'hA5, "R2");
      check_mem(10'h106, 8'h3C, "R1 R2");
      check_mem(10'h107, 8'hFF, "R9 untouched");

      // R9 AND merge
      pulse(wren);
      tx[0] = 8'hF0;
      send_frame(8'hA2, 24'h000105, 1, 0);
      wait_idle();
      check_mem(10'h105, 8'hA0, "R9");

      // R3 wrap within page
      pulse(wren);
      tx[0] = 8'h11; tx[1] = 8'h22; tx[2] = 8'h33;
      send_frame(8'hA2, 24'h0001FE, 3, 0);
      wait_idle();
      check_mem(10'h1FE, 8'h11, "R3");
      check_mem(10'h1FF, 8'h22, "R3");
      check_mem(10'h100, 8'h33, "R3 wrap");
      check_mem(10'h200, 8'hFF, "R3 no carry");

      // R4 mid-byte rise and zero-data frame
      pulse(wren);
      tx[0] = 8'h00;
      send_frame(8'hA2, 24'h000000, 1, 2);
      #1; check_byte(status, 8'h02, "R4 mid-byte");
      send_frame(8'hA2, 24'h000000, 0, 0);
      #1; check_byte(status, 8'h02, "R4 no data");
      check_mem(10'h000, 8'hFF, "R4");

      // R1 wrong opcode
      send_frame(8'h02, 24'h000000, 1, 0);
      #1; check_byte(status, 8'h02, "R1 opcode");

      // R6 protection
      bp = 4'd1; tb = 1'b0;
      send_frame(8'hA2, 24'h000300, 1, 0);
      #1; check_byte(status, 8'h02, "R6 top page");
      tb = 1'b1; bp = 4'd2;
      send_frame(8'hA2, 24'h000020, 1, 0);
      #1; check_byte(status, 8'h02, "R6 bottom pages");
      tx[0] = 8'h5A;
      send_frame(8'hA2, 24'h000200, 1, 0);
      wait_idle();
      check_mem(10'h200, 8'h5A, "R6 open page");
      bp = 4'd0; tb = 1'b0;

      // R10 suspend/resume and R12 activity while busy
      pulse(wren);
      tx[0] = 8'h0F;
      send_frame(8'hA2, 24'h000040, 1, 0);
      repeat (20) @(negedge clk);
      pulse(susp_req);
      #1; check_byte(flag, 8'h04, "R10 suspended");
      pulse(wren);
      tx[0] = 8'h00;
      send_frame(8'hA2, 24'h000041, 1, 0);
      repeat (150) @(negedge clk);
      #1; check_byte(status, 8'h01, "R10 R12 still busy");
      pulse(resume_req);
      wait_idle();
      check_mem(10'h040, 8'h0F, "R10");
      check_mem(10'h041, 8'hFF, "R12");
      check_byte(status, 8'h00, "R12 latch stayed clear");

      // R3 more than 256 bytes
      pulse(wren);
      for (int k = 0; k < 258; k++) tx[k] = 8'(k) ^ 8'hC3;
      send_frame(8'hA2, 24'h000200, 258, 0);
      wait_idle();
      check_mem(10'h200, 8'h42, "R3 overwrite");
      check_mem(10'h201, 8'hC2, "R3 overwrite");
      check_mem(10'h202, 8'hC1, "R3");
      repeat (1100) @(negedge clk);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule